// File: doc/BRIEF.md
# Reset Synchronizer and Start-up Sequencer

This block turns an asynchronous, active-low reset request into a clean system reset for a processor subsystem. The request may fall at any moment. It clears the first flip-flop of a synchronizer at once. Release is passed through the synchronizer chain, so the active-high system reset both rises and falls only on rising clock edges. The system reset stays high for a whole number of clocks, and that number grows with the time the request was held.

After the synchronized release, the block waits a fixed number of clocks and then gives a one-cycle start strobe, which tells a core it may begin fetching. After the strobe, a level output reports that the core is running until the next reset. The block also counts the clocks spent in reset and raises an initialization-quality flag when that count is larger than a required minimum. If a new request arrives during the post-release wait, the wait is abandoned and the whole sequence starts again.

Top module: `reset_sequencer`

## Requirements
- R1: A low level on `req_n`, even one shorter than a clock period, makes `sys_rst` high after the next rising edge of `clk`.
- R2: After `req_n` returns high, `sys_rst` is still high after the first rising edge and falls after the second rising edge (two-stage synchronizer, default `SYNC_STAGES` = 2).
- R3: If K rising edges see `req_n` low, `sys_rst` is high for exactly K+1 clock cycles. A sub-cycle pulse gives K = 0, which means one cycle.
- R4: From the second cycle of `sys_rst` onward, `fetch_go`, `running` and `init_ok` are all 0 (dormant state).
- R5: `fetch_go` rises exactly `START_DELAY` cycles (default 6) after the cycle in which `sys_rst` falls. It is high for a single cycle.
- R6: `running` rises together with `fetch_go` and stays at 1 until `sys_rst` is asserted again.
- R7: One cycle after `sys_rst` falls, `init_ok` becomes 1 if `sys_rst` was high for more than `MIN_CLKS` cycles (default 4), and 0 otherwise. It holds that value until the next reset.
- R8: A request that arrives during the post-release wait suppresses `fetch_go`. After the new release, the full `START_DELAY` wait is timed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock, rising edge active |
| req_n | input | 1 | Asynchronous reset request, active low |
| sys_rst | output | 1 | Synchronized system reset, active high |
| fetch_go | output | 1 | One-cycle strobe allowing instruction fetch to begin |
| running | output | 1 | High from the start strobe until the next reset |
| init_ok | output | 1 | Set when the reset lasted more than `MIN_CLKS` cycles |

## Verification
The hardest cases to reach from the ports lie at the edges of the timing. One is a request pulse that starts and ends between two rising edges and so never gets sampled. Another is a second request that arrives partway through the post-release countdown. The bench drives `req_n` on falling edges and uses a 1 ns offset to make the sub-cycle pulse. It re-asserts the request after a chosen number of countdown cycles and then checks that no strobe leaks out. It also checks that the next strobe still comes the full delay after the new release. Hold lengths of four and five `sys_rst` cycles sit on either side of the `init_ok` threshold.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    SEQ_DORMANT   = 2'd0,
    SEQ_COUNTDOWN = 2'd1,
    SEQ_RUN       = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rstseq_sync.sv
// Asynchronous-assert, synchronous-release chain for the reset request.
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic req_n,
  output logic released
);
  logic              first_q;
  logic [STAGES-2:0] tail_q;
  logic [STAGES-1:0] shifted;

  // Only the first stage sees the request asynchronously.
  always_ff @(posedge clk or negedge req_n) begin
    if (!req_n) first_q <= 1'b0;
    else        first_q <= 1'b1;
  end

  assign shifted = {tail_q, first_q};

  always_ff @(posedge clk) begin
    tail_q <= shifted[STAGES-2:0];
  end

  assign released = tail_q[STAGES-2];
endmodule

// File: rtl/rstseq_dwell.sv
// Counts cycles spent in reset and grades the initialization.
module rstseq_dwell #(
  parameter int MIN_CLKS = 4
) (
  input  logic clk,
  input  logic in_reset,
  output logic init_ok
);
  localparam int SAT = MIN_CLKS + 1;
  localparam int CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);
  localparam logic [CW-1:0] MIN_V = CW'(MIN_CLKS);

  logic [CW-1:0] cnt_q;
  logic          ok_q;

  always_ff @(posedge clk) begin
    if (in_reset) begin
      ok_q  <= 1'b0;
      if (cnt_q != SAT_V) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
      ok_q  <= ok_q | (cnt_q > MIN_V);
    end
  end

  assign init_ok = ok_q;
endmodule

// File: rtl/rstseq_fetch.sv
// Post-release countdown, start strobe and running level.
module rstseq_fetch
  import rstseq_pkg::*;
#(
  parameter int START_DELAY = 6
) (
  input  logic clk,
  input  logic in_reset,
  output logic fetch_go,
  output logic running
);
  localparam int DW = $clog2(START_DELAY + 1);
  localparam logic [DW-1:0] LAST_V = DW'(START_DELAY - 1);

  seq_state_e    state_q;
  logic [DW-1:0] dcnt_q;
  logic          go_q;

  always_ff @(posedge clk) begin
    if (in_reset) begin
      state_q <= SEQ_DORMANT;
      dcnt_q  <= '0;
      go_q    <= 1'b0;
    end else begin
      case (state_q)
        SEQ_DORMANT: begin
          if (LAST_V == '0) begin
            go_q    <= 1'b1;
            state_q <= SEQ_RUN;
          end else begin
            dcnt_q  <= DW'(1);
            state_q <= SEQ_COUNTDOWN;
          end
        end
        SEQ_COUNTDOWN: begin
          if (dcnt_q == LAST_V) begin
            go_q    <= 1'b1;
            state_q <= SEQ_RUN;
          end else begin
            dcnt_q  <= dcnt_q + 1'b1;
          end
        end
        SEQ_RUN: go_q <= 1'b0;
        default: state_q <= SEQ_DORMANT;
      endcase
    end
  end

  assign fetch_go = go_q;
  assign running  = (state_q == SEQ_RUN);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int SYNC_STAGES = 2,
  parameter int START_DELAY = 6,
  parameter int MIN_CLKS    = 4
) (
  input  logic clk,
  input  logic req_n,
  output logic sys_rst,
  output logic fetch_go,
  output logic running,
  output logic init_ok
);
  logic released;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .req_n    (req_n),
    .released (released)
  );

  assign sys_rst = ~released;

  rstseq_dwell #(.MIN_CLKS(MIN_CLKS)) u_dwell (
    .clk      (clk),
    .in_reset (sys_rst),
    .init_ok  (init_ok)
  );

  rstseq_fetch #(.START_DELAY(START_DELAY)) u_fetch (
    .clk      (clk),
    .in_reset (sys_rst),
    .fetch_go (fetch_go),
    .running  (running)
  );
endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk #(
  parameter int START_DELAY = 6
) (
  input logic clk,
  input logic req_n,
  input logic sys_rst,
  input logic fetch_go,
  input logic running,
  input logic init_ok
);
  // Cycles since synchronized release, saturating.
  int unsigned since_rel;
  always_ff @(posedge clk) begin
    if (sys_rst) since_rel <= 0;
    else if (since_rel <= START_DELAY) since_rel <= since_rel + 1;
  end

  assert_dormant_R4: assert property (@(posedge clk)
    (sys_rst && $past(sys_rst)) |-> (!running && !fetch_go && !init_ok));

  assert_release_sync_R2: assert property (@(posedge clk)
    $fell(sys_rst) |-> $past(req_n));

  assert_start_delay_R5: assert property (@(posedge clk) disable iff (sys_rst)
    fetch_go |-> (since_rel == START_DELAY));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (sys_rst)
    fetch_go |=> !fetch_go);

  assert_running_hold_R6: assert property (@(posedge clk)
    (running && !sys_rst) |=> running);

  assert_running_with_go_R6: assert property (@(posedge clk) disable iff (sys_rst)
    $rose(running) |-> fetch_go);

  assert_init_stable_R7: assert property (@(posedge clk) disable iff (sys_rst)
    ($past(!sys_rst) && $past(!sys_rst, 2)) |-> $stable(init_ok));
endmodule

bind reset_sequencer reset_sequencer_chk #(.START_DELAY(START_DELAY)) u_chk (
  .clk      (clk),
  .req_n    (req_n),
  .sys_rst  (sys_rst),
  .fetch_go (fetch_go),
  .running  (running),
  .init_ok  (init_ok)
);

// File: tb/tb_reset_sequencer.sv
`timescale 1ns/1ps
module tb_reset_sequencer;
  localparam int DLY  = 6;
  localparam int MINC = 4;
  localparam int NV   = 6;
  // Edges with req_n low, and expected init_ok (K+1 > MINC).
  localparam int KS [NV] = '{0, 1, 3, 4, 6, 20};
  localparam bit OKS[NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic req_n = 1'b0;
  logic sys_rst, fetch_go, running, init_ok;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reset_sequencer #(.SYNC_STAGES(2), .START_DELAY(DLY), .MIN_CLKS(MINC)) dut (
    .clk(clk), .req_n(req_n), .sys_rst(sys_rst),
    .fetch_go(fetch_go), .running(running), .init_ok(init_ok)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Hold request for k rising edges, then follow the sequence to the strobe.
  task automatic run_case(input int k, input bit exp_ok, input bit full);
    int width = 0;
    int d = 0;
    @(negedge clk); req_n = 1'b0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (sys_rst) width++;
      if (i == 0) chk(sys_rst == 1'b1, "R1 assert after edge", sys_rst, 1);
      if (i == 1) chk(!running && !fetch_go && !init_ok, "R4 dormant", {running, fetch_go, init_ok}, 0);
    end
    if (k == 0) #1;
    req_n = 1'b1;
    @(negedge clk);
    if (sys_rst) width++;
    chk(sys_rst == 1'b1, "R2 still high one edge after release", sys_rst, 1);
    @(negedge clk);
    chk(sys_rst == 1'b0, "R2 low two edges after release", sys_rst, 0);
    chk(width == k + 1, "R3 reset width", width, k + 1);
    if (!full) return;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      d++;
      if (fetch_go) break;
    end
    chk(d == DLY, "R5 start delay", d, DLY);
    chk(running == 1'b1, "R6 running with strobe", running, 1);
    chk(init_ok == exp_ok, "R7 init_ok", init_ok, exp_ok);
    @(negedge clk);
    chk(fetch_go == 1'b0, "R5 single cycle strobe", fetch_go, 0);
  endtask

  initial begin
    int seen;
    // Power-on reset state.
    repeat (3) @(negedge clk);
    chk(sys_rst == 1'b1, "R4 power-on sys_rst", sys_rst, 1);
    chk(!running && !fetch_go, "R4 power-on dormant", {running, fetch_go}, 0);
    req_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(running == 1'b1, "R6 running after power-on", running, 1);

    // Table of hold lengths.
    for (int v = 0; v < NV; v++) run_case(KS[v], OKS[v], 1'b1);

    // R6: running persists while no request.
    repeat (25) @(negedge clk);
    chk(running && !fetch_go, "R6 running held", {running, fetch_go}, 2);

    // R8: abort during countdown.
    run_case(5, 1'b1, 1'b0);
    seen = 0;
    repeat (3) begin
      @(negedge clk);
      if (fetch_go) seen++;
    end
    run_case(2, 1'b0, 1'b0);
    chk(seen == 0, "R8 no strobe before abort", seen, 0);
    chk(!running && !fetch_go, "R8 dormant after abort", {running, fetch_go}, 0);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      seen++;
      if (fetch_go) break;
    end
    chk(seen == DLY, "R8 full delay restarted", seen, DLY);
    chk(init_ok == 1'b0, "R7 short reset after abort", init_ok, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule